// File: doc/BRIEF.md
# Wrapping Address Register Unit

This unit holds twelve 16-bit registers in three groups of four: address pointers, step (index) values and wrap masks. Pointer `k` is paired with step `k` and mask `k`. After a memory access, an instruction may carry an 8-bit suffix that asks for a post-modify of one pointer. The modify can step the pointer down by one, step it up by one, or add its paired step value.

Every modify stays inside a window that the paired mask defines. The mask acts bitwise, so the window is aligned to the mask rather than bounded by a base and a limit. A mask of all ones gives ordinary 16-bit wrap-around. A mask of zero pins the pointer for down-steps.

A plain write/read port reaches all twelve registers. The read port is combinational on the registered state. The suffix port is the only path that changes a pointer by arithmetic, and at most one pointer changes per cycle.

Top module: `wrap_addr_unit`

## Requirements
- R1: After reset every pointer and every step register reads 0x0000 and every mask register reads 0xFFFF.
- R2: Register address bits 3:2 pick the group and bits 1:0 pick the member. Group 0 is the pointers, group 1 the steps and group 2 the masks. A write to address k updates register k at the next clock edge. Addresses 0xC to 0xF read as zero and writes to them change nothing.
- R3: A suffix acts only when `sfx_valid` is high, bits 7:4 are zero and bits 3:2 are nonzero. Bits 3:2 select the operation: 01 is step down, 10 is step up and 11 is add the step value. Bits 1:0 select the pointer. Any other suffix leaves every register unchanged.
- R4: Step down with pointer A and mask M gives A | M when (A & M) is zero, and A - 1 otherwise. With M = 3 and A = 0x10 the sequence is 13, 12, 11, 10, 13. With M = 0 the pointer does not change.
- R5: Step up with pointer A and mask M works as follows. Let t = A + 1, computed with 17 bits, and let c be the carry bits t ^ A ^ 1. If (c & ((M | 1) << 1)) > M the result is t - (M + 1); otherwise it is t. From 0x10 this gives the following sequences: M=3 gives 11,12,13,10; M=2 gives 11,12,13,11; M=4 gives 11..17,13; M=8 gives 11..1F,17; M=0 gives 11,11.
- R6: Add-step uses the rule of R5 with the paired step value S in place of 1 (t = A + S, c = t ^ A ^ S). From 0x10 with S=2 and M=7 the sequence is 12, 14, 16, 10.
- R7: With mask 0xFFFF, a step up from 0xFFFF gives 0x0000 and a step down from 0x0000 gives 0xFFFF.
- R8: When a register write and a suffix modify fall in the same cycle, both take effect. If they target the same pointer, the written value wins. The modify always uses the step and mask values from before the write.
- R9: A suffix modify changes only the selected pointer. All other pointers, all step registers and all mask registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write enable |
| reg_waddr | input | 4 | Register write address |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 16 | Register read data, combinational from state |
| sfx_valid | input | 1 | Suffix present this cycle |
| sfx | input | 8 | Suffix byte: operation in 3:2, pointer in 1:0 |

## Verification
A register write and a pointer modify can land in the same cycle. They may hit the same pointer, or they may hit the step or mask that the modify reads. Directed cycles provoke both cases: a write to a pointer while that pointer steps, and a write to a step register while its pointer adds that step. The bench judges the result by reading the registers afterwards. A random phase also issues writes and suffixes together at random addresses, and a bench model updates first and writes second, then compares every register.

// File: rtl/wrap_pkg.sv
package wrap_pkg;
    localparam int DW     = 16;
    localparam int SFX_W  = 8;
    localparam int SEL_W  = 2;
    localparam int OP_LSB = SEL_W;
    localparam int OP_W   = 2;
    localparam int NSEL   = 1 << SEL_W;
    localparam int GRP_W  = 2;
    localparam int ADDR_W = GRP_W + SEL_W;

    localparam logic [GRP_W-1:0] GRP_PTR  = 2'd0;
    localparam logic [GRP_W-1:0] GRP_STEP = 2'd1;
    localparam logic [GRP_W-1:0] GRP_MASK = 2'd2;

    typedef enum logic [OP_W-1:0] {
        OP_NONE  = 2'b00,
        OP_DEC   = 2'b01,
        OP_INC   = 2'b10,
        OP_ADDIX = 2'b11
    } op_e;
endpackage

// File: rtl/wrap_sfx_dec.sv
module wrap_sfx_dec
    import wrap_pkg::*;
(
    input  logic               sfx_valid,
    input  logic [SFX_W-1:0]   sfx,
    output op_e                op,
    output logic [SEL_W-1:0]   sel
);
    localparam int HI_LSB = OP_LSB + OP_W;

    logic hi_clear;

    always_comb begin
        hi_clear = (sfx[SFX_W-1:HI_LSB] == '0);
        sel      = sfx[SEL_W-1:0];
        if (sfx_valid && hi_clear)
            op = op_e'(sfx[OP_LSB +: OP_W]);
        else
            op = OP_NONE;
    end
endmodule

// File: rtl/wrap_step.sv
module wrap_step
    import wrap_pkg::*;
#(
    parameter int W = DW
) (
    input  op_e          op,
    input  logic [W-1:0] ptr,
    input  logic [W-1:0] step,
    input  logic [W-1:0] mask,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] dec_res;
    logic [W-1:0] addend;
    logic [W:0]   sum;
    logic [W:0]   carries;
    logic [W:0]   win;
    logic         over;
    logic [W-1:0] up_res;

    always_comb begin
        dec_res = ((ptr & mask) == '0) ? (ptr | mask) : (ptr - ONE);

        addend  = (op == OP_ADDIX) ? step : ONE;
        sum     = {1'b0, ptr} + {1'b0, addend};
        carries = sum ^ {1'b0, ptr} ^ {1'b0, addend};
        win     = {mask | ONE, 1'b0};
        over    = (carries & win) > {1'b0, mask};
        up_res  = over ? (sum[W-1:0] - mask - ONE) : sum[W-1:0];

        unique case (op)
            OP_DEC:  nxt = dec_res;
            OP_NONE: nxt = ptr;
            default: nxt = up_res;
        endcase
    end
endmodule

// File: rtl/wrap_addr_unit.sv
module wrap_addr_unit
    import wrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [DW-1:0]     reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [DW-1:0]     reg_rdata,
    input  logic              sfx_valid,
    input  logic [SFX_W-1:0]  sfx
);
    typedef logic [DW-1:0] word_t;
    typedef struct packed {
        word_t [NSEL-1:0] ptr;
        word_t [NSEL-1:0] step;
        word_t [NSEL-1:0] mask;
    } state_t;

    localparam state_t ST_RST = '{ptr: '0, step: '0, mask: '1};
    localparam word_t  ONE_W  = DW'(1);

    state_t st_d, st_q;
    op_e              upd_op;
    logic [SEL_W-1:0] upd_sel;
    word_t            upd_val;

    function automatic word_t pick(state_t s, logic [ADDR_W-1:0] a);
        logic [SEL_W-1:0] m;
        m = a[SEL_W-1:0];
        case (a[ADDR_W-1:SEL_W])
            GRP_PTR:  return s.ptr[m];
            GRP_STEP: return s.step[m];
            GRP_MASK: return s.mask[m];
            default:  return '0;
        endcase
    endfunction

    wrap_sfx_dec u_dec (
        .sfx_valid (sfx_valid),
        .sfx       (sfx),
        .op        (upd_op),
        .sel       (upd_sel)
    );

    wrap_step #(.W(DW)) u_step (
        .op   (upd_op),
        .ptr  (st_q.ptr[upd_sel]),
        .step (st_q.step[upd_sel]),
        .mask (st_q.mask[upd_sel]),
        .nxt  (upd_val)
    );

    always_comb begin
        st_d = st_q;
        if (upd_op != OP_NONE)
            st_d.ptr[upd_sel] = upd_val;
        if (reg_we) begin
            case (reg_waddr[ADDR_W-1:SEL_W])
                GRP_PTR:  st_d.ptr[reg_waddr[SEL_W-1:0]]  = reg_wdata;
                GRP_STEP: st_d.step[reg_waddr[SEL_W-1:0]] = reg_wdata;
                GRP_MASK: st_d.mask[reg_waddr[SEL_W-1:0]] = reg_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign reg_rdata = pick(st_q, reg_raddr);

    // R2 / R8: a write to a mapped address lands, whatever the suffix does
    a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr[ADDR_W-1:SEL_W] != 2'd3)
        |=> pick(st_q, $past(reg_waddr)) == $past(reg_wdata));

    // R3: no write and no decoded suffix keeps all state
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && upd_op == OP_NONE) |=> $stable(st_q));

    // R9: a modify alone touches no step or mask register
    a_r9_only_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && upd_op != OP_NONE) |=> ($stable(st_q.step) && $stable(st_q.mask)));

    // R4: a zero mask pins the pointer on step down
    a_r4_zero_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && upd_op == OP_DEC && st_q.mask[upd_sel] == '0)
        |=> $stable(st_q.ptr));

    // R7: all-ones mask makes step up a plain modulo add
    a_r7_full_mask_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_we && upd_op == OP_INC && st_q.mask[upd_sel] == '1)
        |=> st_q.ptr[$past(upd_sel)] == $past(st_q.ptr[upd_sel]) + ONE_W);
endmodule

// File: tb/sim_wrap_addr_unit.sv
`timescale 1ns/10ps
module sim_wrap_addr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [15:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [15:0] reg_rdata;
    logic        sfx_valid = 1'b0;
    logic [7:0]  sfx = '0;

    int n_chk = 0;
    int n_err = 0;
    logic [15:0] m [12];

    always #5 clk = ~clk;

    wrap_addr_unit u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .sfx_valid(sfx_valid), .sfx(sfx)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        reg_raddr = a;
        #0.1;
        v = reg_rdata;
    endtask

    task automatic check_all(string req);
        logic [15:0] v;
        for (int i = 0; i < 16; i++) begin
            rd(i[3:0], v);
            chk($sformatf("%s reg %0d", req, i), v, (i < 12) ? m[i] : 16'h0);
        end
    endtask

    function automatic logic [15:0] ref_step(logic [1:0] op, logic [15:0] a,
                                             logic [15:0] s, logic [15:0] k);
        logic [16:0] t, c, w;
        logic [15:0] ad;
        if (op == 2'b01) return ((a & k) == 16'h0) ? (a | k) : a - 16'h1;
        ad = (op == 2'b11) ? s : 16'h1;
        t  = {1'b0, a} + {1'b0, ad};
        c  = t ^ {1'b0, a} ^ {1'b0, ad};
        w  = {k | 16'h1, 1'b0};
        if ((c & w) > {1'b0, k}) t = t - ({1'b0, k} + 17'h1);
        return t[15:0];
    endfunction

    task automatic cyc(logic we, logic [3:0] wa, logic [15:0] wd, logic sv, logic [7:0] sf);
        logic [1:0] p;
        reg_we = we; reg_waddr = wa; reg_wdata = wd; sfx_valid = sv; sfx = sf;
        @(posedge clk);
        p = sf[1:0];
        if (sv && sf[7:4] == 4'h0 && sf[3:2] != 2'b00)
            m[p] = ref_step(sf[3:2], m[p], m[4 + p], m[8 + p]);
        if (we && wa < 4'd12) m[wa] = wd;
        @(negedge clk);
        reg_we = 1'b0; sfx_valid = 1'b0; sfx = '0;
    endtask

    task automatic wr_reg(logic [3:0] a, logic [15:0] d);
        cyc(1'b1, a, d, 1'b0, 8'h00);
    endtask

    task automatic run_seq(string req, logic [3:0] nib, logic [15:0] exp[$]);
        logic [15:0] v;
        foreach (exp[i]) begin
            cyc(1'b0, 4'h0, 16'h0, 1'b1, {4'h0, nib});
            rd({2'b00, nib[1:0]}, v);
            chk($sformatf("%s step %0d", req, i), v, exp[i]);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++; n_err++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd11));
        for (int i = 0; i < 12; i++) m[i] = (i >= 8) ? 16'hFFFF : 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 reset");

        for (int i = 0; i < 12; i++) wr_reg(i[3:0], 16'h1000 + 16'(i * 16'h111));
        wr_reg(4'hD, 16'hBEEF);
        check_all("R2 rw");

        // R4 step down
        wr_reg(4'd1, 16'h0010); wr_reg(4'd5, 16'h0); wr_reg(4'd9, 16'h3);
        run_seq("R4 m3", 4'b0101, '{16'h13, 16'h12, 16'h11, 16'h10, 16'h13});
        wr_reg(4'd1, 16'h0010); wr_reg(4'd9, 16'h0);
        run_seq("R4 m0", 4'b0101, '{16'h10, 16'h10});

        // R5 step up
        wr_reg(4'd1, 16'h0010); wr_reg(4'd9, 16'h3);
        run_seq("R5 m3", 4'b1001, '{16'h11, 16'h12, 16'h13, 16'h10, 16'h11});
        wr_reg(4'd1, 16'h0010); wr_reg(4'd9, 16'h2);
        run_seq("R5 m2", 4'b1001, '{16'h11, 16'h12, 16'h13, 16'h11, 16'h12, 16'h13});
        wr_reg(4'd1, 16'h0010); wr_reg(4'd9, 16'h4);
        run_seq("R5 m4", 4'b1001, '{16'h11, 16'h12, 16'h13, 16'h14, 16'h15, 16'h16,
                                    16'h17, 16'h13, 16'h14});
        wr_reg(4'd1, 16'h0010); wr_reg(4'd9, 16'h8);
        run_seq("R5 m8", 4'b1001, '{16'h11, 16'h12, 16'h13, 16'h14, 16'h15, 16'h16,
                                    16'h17, 16'h18, 16'h19, 16'h1A, 16'h1B, 16'h1C,
                                    16'h1D, 16'h1E, 16'h1F, 16'h17, 16'h18});
        wr_reg(4'd1, 16'h0010); wr_reg(4'd9, 16'h0);
        run_seq("R5 m0", 4'b1001, '{16'h11, 16'h11, 16'h11});

        // R6 add step
        wr_reg(4'd1, 16'h0010); wr_reg(4'd5, 16'h2); wr_reg(4'd9, 16'h7);
        run_seq("R6 s2m7", 4'b1101, '{16'h12, 16'h14, 16'h16, 16'h10, 16'h12});
        wr_reg(4'd1, 16'h0010); wr_reg(4'd5, 16'h1); wr_reg(4'd9, 16'h3);
        run_seq("R6 s1m3", 4'b1101, '{16'h11, 16'h12, 16'h13, 16'h10});

        // R7 full mask
        wr_reg(4'd2, 16'hFFFF); wr_reg(4'd10, 16'hFFFF);
        run_seq("R7 up", 4'b1010, '{16'h0000, 16'h0001});
        run_seq("R7 down", 4'b0110, '{16'h0000, 16'hFFFF});

        // R3 ignored suffixes
        wr_reg(4'd3, 16'h0040); wr_reg(4'd11, 16'hFFFF);
        cyc(1'b0, 4'h0, 16'h0, 1'b1, 8'h17);
        check_all("R3 high bits");
        cyc(1'b0, 4'h0, 16'h0, 1'b1, 8'h03);
        check_all("R3 op zero");
        cyc(1'b0, 4'h0, 16'h0, 1'b0, 8'h07);
        check_all("R3 not valid");

        // R8 write against modify
        wr_reg(4'd0, 16'h0020); wr_reg(4'd8, 16'hFFFF);
        cyc(1'b1, 4'd0, 16'h5555, 1'b1, 8'h08);
        rd(4'd0, v); chk("R8 same ptr", v, 16'h5555);
        wr_reg(4'd0, 16'h0010); wr_reg(4'd4, 16'h0004);
        cyc(1'b1, 4'd4, 16'h0100, 1'b1, 8'h0C);
        rd(4'd0, v); chk("R8 old step used", v, 16'h0014);
        rd(4'd4, v); chk("R8 step written", v, 16'h0100);
        check_all("R9 others kept");

        // random phase: R4 R5 R6 R8 R9
        for (int n = 0; n < 4000; n++) begin
            logic        we, sv;
            logic [3:0]  wa;
            logic [15:0] wd;
            logic [7:0]  sf;
            we = ($urandom % 4) == 0;
            wa = 4'($urandom % 16);
            if (wa >= 4'd8 && wa < 4'd12)
                wd = 16'((32'h1 << ($urandom % 17)) - 1);
            else if (wa >= 4'd4 && wa < 4'd8)
                wd = 16'($urandom % 9);
            else
                wd = 16'($urandom);
            sv = ($urandom % 8) != 0;
            sf = 8'($urandom % 16);
            if (($urandom % 16) == 0) sf = 8'($urandom);
            cyc(we, wa, wd, sv, sf);
            rd(4'($urandom % 16), v);
            chk($sformatf("R9 random rd %0d", reg_raddr), v,
                (reg_raddr < 4'd12) ? m[reg_raddr] : 16'h0);
            if (n % 200 == 199) check_all("R5 R6 random");
        end
        finish_run();
    end
endmodule